// File: doc/BRIEF.md
# Configuration Transaction Bridge Registers

This block is a small memory-mapped register window that lets a host processor run one single-word transaction at a time on a slow downstream configuration bus. To run a transaction the host does four things. It puts the write operand in the data register. It clears the status register. It writes a control word that holds a start flag, a direction flag, a site selector and a target configuration address. It then polls the status register until the completion flag or the error flag is set.

The sequencer inside the block takes the command and copies the operand into a private latch. It then raises a request on a request/acknowledge downstream port and holds it until the far side answers. If the far side never answers, a programmable cycle-count limit ends the wait. When a read completes, the returned word replaces the contents of the data register. When a transaction fails, the data register keeps its old value.

Top module: `cfgb_bridge`

## Requirements
- R1: Host offsets are data 0xA0, control 0xA4, status 0xA8 and timeout limit 0xAC, the limit being zero-extended on readback. Every mapped register can be read back. A read of any other offset, 0xA1 and 0xB0 included, returns zero.
- R2: In the control word, bit 31 is the start flag, bit 30 selects a write when set, bits 19:16 are the site and bits 11:0 are the target address. A start written while idle reads back as 1 in the cycle after the write and as 0 from the next cycle on. The other fields keep their values.
- R3: While a request is up, `dn_write`, `dn_site` and `dn_addr` follow the control fields. `dn_wdata` holds the data register value taken when the command launched, even if the host rewrites the data register during the transaction.
- R4: `dn_req` rises once per accepted command. It stays high until a cycle in which `dn_ack` is high, or until the timeout ends the wait.
- R5: A read acknowledged with `dn_err` low sets status bit 0 and overwrites the data register with `dn_rdata`.
- R6: An acknowledge with `dn_err` high sets status bit 1, leaves bit 0 clear and leaves the data register unchanged.
- R7: With a nonzero limit N and no acknowledge, `dn_req` is high for exactly N clock cycles. The block then sets status bit 1 and leaves bit 0 clear. A limit of zero turns the timeout off.
- R8: Both status flags are sticky. Any host write to offset 0xA8 clears both flags. A flag set in the same cycle as such a write takes priority over the clear.
- R9: A control write is ignored while a transaction is in flight or a start is pending. The control readback keeps its old value and no second request is issued.
- R10: After reset every register reads zero and `dn_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| dn_req | output | 1 | Downstream request |
| dn_write | output | 1 | Downstream direction, 1 for write |
| dn_site | output | 4 | Downstream site selector |
| dn_addr | output | 12 | Downstream target address |
| dn_wdata | output | 32 | Downstream write operand |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_err | input | 1 | Downstream error, valid with `dn_ack` |
| dn_rdata | input | 32 | Downstream read word, valid with `dn_ack` |

## Verification
The case that is hardest to reach from the ports is host traffic arriving while a transaction is open. The bench has to show that a second control write and a new data value both leave the open transaction untouched. To get there, the bench's downstream responder is told to hold back its acknowledge for twenty cycles. The bench writes new control and data values inside that window. When the acknowledge arrives, it compares the operand the responder saw and the total count of requests against what was first programmed. The timeout path is reached by turning the responder off and counting how many cycles the request stays high.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

  localparam int HOST_AW = 8;
  localparam logic [HOST_AW-1:0] OFS_DATA = 8'hA0;
  localparam logic [HOST_AW-1:0] OFS_CTRL = 8'hA4;
  localparam logic [HOST_AW-1:0] OFS_STAT = 8'hA8;
  localparam logic [HOST_AW-1:0] OFS_TMO  = 8'hAC;

  localparam int START_BIT = 31;
  localparam int WRITE_BIT = 30;
  localparam int SITE_LSB  = 16;

  typedef enum logic [0:0] {SEQ_IDLE, SEQ_BUSY} seq_state_e;

  // Wait ends once the held request has used up its allowed cycles.
  function automatic logic wait_spent(input logic [31:0] held, input logic [31:0] limit);
    return (limit != 32'd0) && ((held + 32'd1) >= limit);
  endfunction

  // Assemble the control readback word from its fields.
  function automatic logic [31:0] ctrl_word(input logic start, input logic wr,
                                            input logic [31:0] site, input logic [31:0] addr,
                                            input int site_w, input int addr_w);
    logic [31:0] w;
    w = 32'd0;
    w[START_BIT] = start;
    w[WRITE_BIT] = wr;
    for (int i = 0; i < site_w; i++) w[SITE_LSB + i] = site[i];
    for (int i = 0; i < addr_w; i++) w[i] = addr[i];
    return w;
  endfunction

endpackage

// File: rtl/cfgb_regs.sv
module cfgb_regs
  import cfgb_pkg::*;
#(
  parameter int SITE_W  = 4,
  parameter int CADDR_W = 12,
  parameter int TMO_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               launch,
  input  logic               busy,
  input  logic               done_ok,
  input  logic               done_err,
  input  logic               rd_cap,
  input  logic [31:0]        rd_word,
  output logic               start_q,
  output logic               wr_q,
  output logic [SITE_W-1:0]  site_q,
  output logic [CADDR_W-1:0] addr_q,
  output logic [31:0]        data_q,
  output logic [TMO_W-1:0]   limit_q
);

  logic cmpl_q, err_q;
  logic wr_data, wr_ctrl, wr_stat, wr_tmo, ctrl_open;

  assign wr_data   = host_we && (host_addr == OFS_DATA);
  assign wr_ctrl   = host_we && (host_addr == OFS_CTRL);
  assign wr_stat   = host_we && (host_addr == OFS_STAT);
  assign wr_tmo    = host_we && (host_addr == OFS_TMO);
  assign ctrl_open = !busy && !start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (rd_cap) begin
      data_q <= rd_word;
    end else if (wr_data) begin
      data_q <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      wr_q    <= 1'b0;
      site_q  <= '0;
      addr_q  <= '0;
    end else if (wr_ctrl && ctrl_open) begin
      start_q <= host_wdata[START_BIT];
      wr_q    <= host_wdata[WRITE_BIT];
      site_q  <= host_wdata[SITE_LSB +: SITE_W];
      addr_q  <= host_wdata[CADDR_W-1:0];
    end else if (launch) begin
      start_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpl_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (done_ok)      cmpl_q <= 1'b1;
      else if (wr_stat) cmpl_q <= 1'b0;
      if (done_err)     err_q  <= 1'b1;
      else if (wr_stat) err_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      limit_q <= '0;
    else if (wr_tmo) limit_q <= host_wdata[TMO_W-1:0];
  end

  always_comb begin
    unique case (host_addr)
      OFS_DATA: host_rdata = data_q;
      OFS_CTRL: host_rdata = ctrl_word(start_q, wr_q, 32'(site_q), 32'(addr_q), SITE_W, CADDR_W);
      OFS_STAT: host_rdata = {30'd0, err_q, cmpl_q};
      OFS_TMO:  host_rdata = 32'(limit_q);
      default:  host_rdata = 32'd0;
    endcase
  end

  assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !start_q);

  assert_ctrl_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || start_q) |=> $stable({wr_q, site_q, addr_q}));

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap |=> (data_q == $past(rd_word)));

  assert_err_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_err && !wr_data) |=> $stable(data_q));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_err) |=> (cmpl_q || err_q));

endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq
  import cfgb_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_q,
  input  logic             wr_q,
  input  logic [31:0]      data_q,
  input  logic [TMO_W-1:0] limit_q,
  input  logic             dn_ack,
  input  logic             dn_err,
  output logic             launch,
  output logic             busy,
  output logic             done_ok,
  output logic             done_err,
  output logic             tmo_hit,
  output logic             rd_cap,
  output logic [31:0]      op_q
);

  seq_state_e       state_q;
  logic [TMO_W-1:0] held_q;

  assign busy     = (state_q == SEQ_BUSY);
  assign launch   = (state_q == SEQ_IDLE) && start_q;
  assign tmo_hit  = busy && !dn_ack && wait_spent(32'(held_q), 32'(limit_q));
  assign done_ok  = busy && dn_ack && !dn_err;
  assign done_err = busy && ((dn_ack && dn_err) || tmo_hit);
  assign rd_cap   = done_ok && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      held_q  <= '0;
      op_q    <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_q) begin
            state_q <= SEQ_BUSY;
            held_q  <= '0;
            op_q    <= data_q;
          end
        end
        SEQ_BUSY: begin
          if (dn_ack || tmo_hit) state_q <= SEQ_IDLE;
          else                   held_q  <= held_q + 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dn_ack && !tmo_hit) |=> busy);

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_ok, done_err}));

  assert_tmo_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> !busy);

  assert_op_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q));

endmodule

// File: rtl/cfgb_bridge.sv
module cfgb_bridge
  import cfgb_pkg::*;
#(
  parameter int SITE_W  = 4,
  parameter int CADDR_W = 12,
  parameter int TMO_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [7:0]         host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               dn_req,
  output logic               dn_write,
  output logic [SITE_W-1:0]  dn_site,
  output logic [CADDR_W-1:0] dn_addr,
  output logic [31:0]        dn_wdata,
  input  logic               dn_ack,
  input  logic               dn_err,
  input  logic [31:0]        dn_rdata
);

  logic               launch, busy, done_ok, done_err, tmo_hit, rd_cap;
  logic               start_q, wr_q;
  logic [SITE_W-1:0]  site_q;
  logic [CADDR_W-1:0] addr_q;
  logic [31:0]        data_q, op_q;
  logic [TMO_W-1:0]   limit_q;

  cfgb_regs #(.SITE_W(SITE_W), .CADDR_W(CADDR_W), .TMO_W(TMO_W)) u_regs (
    .clk, .rst_n, .host_we, .host_addr, .host_wdata, .host_rdata,
    .launch, .busy, .done_ok, .done_err, .rd_cap, .rd_word(dn_rdata),
    .start_q, .wr_q, .site_q, .addr_q, .data_q, .limit_q
  );

  cfgb_seq #(.TMO_W(TMO_W)) u_seq (
    .clk, .rst_n, .start_q, .wr_q, .data_q, .limit_q, .dn_ack, .dn_err,
    .launch, .busy, .done_ok, .done_err, .tmo_hit, .rd_cap, .op_q
  );

  assign dn_req   = busy;
  assign dn_write = wr_q;
  assign dn_site  = site_q;
  assign dn_addr  = addr_q;
  assign dn_wdata = op_q;

  assert_single_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req) |-> $past(start_q));

endmodule

// File: tb/cfgb_bridge_tb.sv
module cfgb_bridge_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = 8'h00;
  logic [31:0] host_wdata = 32'd0;
  logic [31:0] host_rdata;
  logic        dn_req, dn_write;
  logic [3:0]  dn_site;
  logic [11:0] dn_addr;
  logic [31:0] dn_wdata;
  logic        dn_ack = 1'b0;
  logic        dn_err = 1'b0;
  logic [31:0] dn_rdata = 32'd0;

  // responder controls (set by the main process)
  logic        resp_en = 1'b1;
  logic        resp_err = 1'b0;
  logic [31:0] resp_data = 32'd0;
  int          resp_delay = 2;
  // responder observations (written only by the responder)
  logic        seen_write;
  logic [3:0]  seen_site;
  logic [11:0] seen_addr;
  logic [31:0] seen_wdata;
  int          req_cycles = 0;
  int          launches = 0;

  int checks = 0;
  int errors = 0;

  cfgb_bridge u_dut (
    .clk, .rst_n, .host_we, .host_addr, .host_wdata, .host_rdata,
    .dn_req, .dn_write, .dn_site, .dn_addr, .dn_wdata,
    .dn_ack, .dn_err, .dn_rdata
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (dn_req) req_cycles <= req_cycles + 1;

  initial begin : responder
    int wait_n;
    logic prev;
    wait_n = 0;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      dn_ack = 1'b0;
      dn_err = 1'b0;
      if (dn_req && !prev) launches = launches + 1;
      prev = dn_req;
      if (dn_req && resp_en) begin
        if (wait_n >= resp_delay) begin
          dn_ack = 1'b1;
          dn_err = resp_err;
          dn_rdata = resp_data;
          seen_write = dn_write;
          seen_site = dn_site;
          seen_addr = dn_addr;
          seen_wdata = dn_wdata;
          wait_n = 0;
        end else begin
          wait_n = wait_n + 1;
        end
      end else begin
        wait_n = 0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1;
    host_addr = a;
    host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic read_now(input logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic poll_status(output logic [31:0] st);
    st = 32'd0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      read_now(8'hA8, st);
      if (st != 32'd0) break;
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input logic wr, input logic [3:0] site, input logic [11:0] a);
    return 32'h8000_0000 | (32'(wr) << 30) | (32'(site) << 16) | 32'(a);
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    read_now(8'hA0, d); check("R10 data after reset", d, 0);
    read_now(8'hA4, d); check("R10 ctrl after reset", d, 0);
    read_now(8'hA8, d); check("R10 status after reset", d, 0);
    read_now(8'hAC, d); check("R10 limit after reset", d, 0);
    check("R10 dn_req after reset", 32'(dn_req), 0);
  endtask

  task automatic t_write_txn;
    logic [31:0] d;
    int l0;
    l0 = launches;
    resp_en = 1'b1; resp_err = 1'b0; resp_delay = 3;
    host_write(8'hA0, 32'h1234_5678);
    host_write(8'hA8, 32'd0);
    host_write(8'hA4, mk_ctrl(1'b1, 4'd5, 12'h03A));
    read_now(8'hA4, d); check("R2 start pending readback", d, 32'hC005_003A);
    @(negedge clk);
    read_now(8'hA4, d); check("R2 start self-clears", d, 32'h4005_003A);
    poll_status(d);
    check("R5 write completes", d, 32'h1);
    check("R3 dn_write", 32'(seen_write), 1);
    check("R3 dn_site", 32'(seen_site), 5);
    check("R3 dn_addr", 32'(seen_addr), 32'h03A);
    check("R3 dn_wdata operand", seen_wdata, 32'h1234_5678);
    check("R4 one request per command", 32'(launches - l0), 1);
  endtask

  task automatic t_read_txn;
    logic [31:0] d;
    resp_data = 32'hCAFE_F00D; resp_err = 1'b0; resp_delay = 1;
    host_write(8'hA0, 32'hDEAD_BEEF);
    host_write(8'hA8, 32'd0);
    read_now(8'hA8, d); check("R8 status cleared by write", d, 0);
    host_write(8'hA4, mk_ctrl(1'b0, 4'd2, 12'h007));
    poll_status(d);
    check("R5 read completes", d, 32'h1);
    read_now(8'hA0, d); check("R5 read word overwrites data", d, 32'hCAFE_F00D);
    check("R3 read direction", 32'(seen_write), 0);
    repeat (10) @(negedge clk);
    read_now(8'hA8, d); check("R8 complete flag sticky", d, 32'h1);
  endtask

  task automatic t_err_resp;
    logic [31:0] d;
    resp_data = 32'h5555_AAAA; resp_err = 1'b1; resp_delay = 2;
    host_write(8'hA0, 32'h1111_1111);
    host_write(8'hA8, 32'd0);
    host_write(8'hA4, mk_ctrl(1'b0, 4'd1, 12'h100));
    poll_status(d);
    check("R6 error flag only", d, 32'h2);
    read_now(8'hA0, d); check("R6 data unchanged on error", d, 32'h1111_1111);
    resp_err = 1'b0;
  endtask

  task automatic t_timeout;
    logic [31:0] d;
    int c0;
    host_write(8'hAC, 32'd5);
    read_now(8'hAC, d); check("R1 limit readback", d, 5);
    host_write(8'hA8, 32'd0);
    resp_en = 1'b0;
    c0 = req_cycles;
    host_write(8'hA4, mk_ctrl(1'b0, 4'd3, 12'h0FF));
    poll_status(d);
    @(negedge clk);
    check("R7 timeout sets error only", d, 32'h2);
    check("R7 request held N cycles", 32'(req_cycles - c0), 5);
    check("R7 request dropped", 32'(dn_req), 0);
    host_write(8'hA8, 32'hFFFF_FFFF);
    read_now(8'hA8, d); check("R8 any status write clears", d, 0);
    resp_en = 1'b1;
    host_write(8'hAC, 32'd0);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] d;
    int l0;
    l0 = launches;
    resp_delay = 20; resp_data = 32'h0BAD_0001;
    host_write(8'hA0, 32'hA5A5_0F0F);
    host_write(8'hA8, 32'd0);
    host_write(8'hA4, mk_ctrl(1'b1, 4'd1, 12'h001));
    host_write(8'hA4, mk_ctrl(1'b0, 4'd9, 12'h222));
    host_write(8'hA0, 32'h0000_0000);
    read_now(8'hA4, d); check("R9 ctrl write ignored while busy", d, 32'h4001_0001);
    poll_status(d);
    check("R7 zero limit never times out", d, 32'h1);
    check("R3 operand latched at launch", seen_wdata, 32'hA5A5_0F0F);
    check("R9 no second request", 32'(launches - l0), 1);
    check("R9 site unchanged downstream", 32'(seen_site), 1);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    @(negedge clk);
    read_now(8'hA1, d); check("R1 offset 0xA1 reads zero", d, 0);
    read_now(8'hB0, d); check("R1 offset 0xB0 reads zero", d, 0);
    read_now(8'h00, d); check("R1 offset 0x00 reads zero", d, 0);
    read_now(8'hA0, d); check("R1 data readable", d, 32'h0000_0000);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_txn();
    t_read_txn();
    t_err_resp();
    t_timeout();
    t_busy_ignore();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule